// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block makes the keep-or-discard call for each incoming Ethernet frame from two facts about it: its destination address and its length. The six destination bytes arrive together on one parallel input, first byte in the top octet, alongside the frame length and a valid pulse. One clock later the block returns a one-cycle verdict strobe with an accept flag.

The filter owns a small bank of configuration words, loaded through a single write port:
- a drop-enable word;
- a don't-care word that overrides the drop-enable word;
- two words that hold the 48-bit station address;
- a length limit.

Broadcast and multicast frames each follow their own pair of control bits. In each pair the don't-care bit wins over the drop bit. A unicast frame passes only when its address matches the station address exactly. The length limit is applied before any of the address rules.

Top module: `rxf_top`

## Requirements
- R1: Each `in_valid` pulse produces exactly one `out_valid` pulse on the next clock edge. `out_valid` never rises without a preceding `in_valid`, and `accept` is low whenever `out_valid` is low.
- R2: A frame whose `frame_len` is greater than bits [15:0] of the length-limit word is dropped, whatever its destination. A length equal to the limit is not rejected by this rule.
- R3: A destination of all ones is treated as broadcast. It follows only the broadcast rule, even though its first byte also has bit 0 set.
- R4: Broadcast policy:
  - if bit 9 of the don't-care word is 1, the frame is accepted;
  - otherwise, if bit 9 of the drop-enable word is 1, the frame is dropped;
  - otherwise it is accepted.
- R5: A destination whose first byte (`dest_addr[47:40]`) has bit 0 set, and that is not all ones, is multicast. It follows the rule of R4, using bit 8 of both words in place of bit 9.
- R6: Any other destination is accepted only if all 48 bits equal the station address. The station address is `{word2[31:0], word3[31:16]}`, with octet 1 in `word2[31:24]`. Bits [15:0] of word 3 have no effect.
- R7: The reset values of the configuration words are:
  - drop-enable word: 0;
  - don't-care word: 0x3FFFF;
  - both station address words: 0;
  - length-limit word: 0x600.
- R8: When `cfg_we` is high at a clock edge, that edge writes `cfg_wdata` into the word chosen by `cfg_sel`. The select codes are: 0 drop-enable, 1 don't-care, 2 station word 2, 3 station word 3, 4 length limit. Other codes write nothing. A frame sampled at any later edge sees the new value.
- R9: Bits [31:16] of the length-limit word have no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Destination and length are valid this cycle |
| dest_addr | input | 48 | Destination address, first frame byte in [47:40] |
| frame_len | input | 16 | Frame length in bytes |
| out_valid | output | 1 | Verdict strobe, one cycle after `in_valid` |
| accept | output | 1 | High with `out_valid` when the frame is kept |

## Verification
The bench builds the filter with its default parameters: a 48-bit address, a 16-bit length and control bits 9 and 8. These keep the policy state small.

It sweeps all sixteen settings of the four policy bits, and under each setting it sends:
- a broadcast address;
- two multicast shapes, one of them with a first byte of 0xFF;
- a matching unicast address;
- six unicast addresses that each differ from the station in one octet.

The length limit is probed on both sides of its boundary, with junk in its upper half. The reset-time policy is checked before any configuration write.

// File: rtl/rxf_pkg.sv
// Package: shared widths, configuration select codes and the
// configuration record used by the receive address filter.
package rxf_pkg;
    localparam int REG_W  = 32;
    localparam int NREGS  = 5;
    localparam int SEL_W  = 3;

    // Configuration word select codes (cfg_sel).
    localparam logic [SEL_W-1:0] SEL_DROP   = 3'd0;
    localparam logic [SEL_W-1:0] SEL_DCARE  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_STA_A  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_STA_B  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_MAXLEN = 3'd4;

    typedef struct packed {
        logic [REG_W-1:0] drop_w;
        logic [REG_W-1:0] dcare_w;
        logic [REG_W-1:0] sta_a;
        logic [REG_W-1:0] sta_b;
        logic [REG_W-1:0] maxlen;
    } cfg_t;
endpackage

// File: rtl/rxf_cfg_regs.sv
// Configuration bank: holds the five filter words. One write port
// selects a word by code; reset loads the per-word reset values.
// Assumes a synchronous active-low reset, and that a write and a
// reset never need to coexist (reset wins).
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter logic [REG_W-1:0] DCARE_RST  = 32'h0003_FFFF,
    parameter logic [REG_W-1:0] MAXLEN_RST = 32'h0000_0600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [REG_W-1:0] wdata,
    output cfg_t             cfg
);
    logic [REG_W-1:0] words [NREGS];

    // Reset value of word i.
    function automatic logic [REG_W-1:0] rst_val(input int i);
        case (i)
            int'(SEL_DCARE):  return DCARE_RST;
            int'(SEL_MAXLEN): return MAXLEN_RST;
            default:          return '0;
        endcase
    endfunction

    for (genvar i = 0; i < NREGS; i++) begin : g_word
        // Holds word i; reset or a write addressed to code i updates it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[i] <= rst_val(i);
            end else if (wr_en && (sel == SEL_W'(i))) begin
                words[i] <= wdata;
            end
        end
    end

    // Publish the words as a named record.
    assign cfg.drop_w  = words[int'(SEL_DROP)];
    assign cfg.dcare_w = words[int'(SEL_DCARE)];
    assign cfg.sta_a   = words[int'(SEL_STA_A)];
    assign cfg.sta_b   = words[int'(SEL_STA_B)];
    assign cfg.maxlen  = words[int'(SEL_MAXLEN)];
endmodule

// File: rtl/rxf_classify.sv
// Destination classifier: flags broadcast (all ones), multicast
// (group bit of the first byte, not broadcast) and an exact station
// match. Purely combinational; byte 0 of the frame sits in the top octet.
module rxf_classify #(
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] dest,
    input  logic [ADDR_W-1:0] station,
    output logic              is_bcast,
    output logic              is_mcast,
    output logic              ucast_hit
);
    localparam int NBYTES = ADDR_W / 8;

    logic [NBYTES-1:0] byte_ones;
    logic [NBYTES-1:0] byte_eq;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign byte_ones[b] = &dest[b*8 +: 8];
        assign byte_eq[b]   = (dest[b*8 +: 8] == station[b*8 +: 8]);
    end

    // Classify: broadcast first, then the group bit of the first byte.
    always_comb begin
        is_bcast  = &byte_ones;
        is_mcast  = dest[ADDR_W-8] && !is_bcast;
        ucast_hit = &byte_eq;
    end
endmodule

// File: rtl/rxf_decide.sv
// Verdict stage: applies the length limit, then the broadcast or
// multicast don't-care/drop policy or the unicast match, and registers
// the verdict as a one-cycle strobe. Assumes classifier flags are
// consistent with the sampled address in the same cycle.
module rxf_decide #(
    parameter int LEN_W  = 16,
    parameter int BC_BIT = 9,
    parameter int MC_BIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [LEN_W-1:0] len_limit,
    input  logic [1:0]       drop_bits,   // {broadcast, multicast}
    input  logic [1:0]       dcare_bits,  // {broadcast, multicast}
    input  logic             is_bcast,
    input  logic             is_mcast,
    input  logic             ucast_hit,
    output logic             out_valid,
    output logic             accept
);
    logic len_ok;
    logic bc_pass;
    logic mc_pass;
    logic verdict;

    // Policy: don't-care overrides drop; length limit overrides all.
    always_comb begin
        len_ok  = (frame_len <= len_limit);
        bc_pass = dcare_bits[1] || !drop_bits[1];
        mc_pass = dcare_bits[0] || !drop_bits[0];
        if (!len_ok)       verdict = 1'b0;
        else if (is_bcast) verdict = bc_pass;
        else if (is_mcast) verdict = mc_pass;
        else               verdict = ucast_hit;
    end

    // Register the strobe and the verdict qualified by it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            accept    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            accept    <= in_valid && verdict;
        end
    end

    // Bit positions are carried for documentation of the wiring above.
    localparam int BIT_GAP = BC_BIT - MC_BIT;
    if (BIT_GAP == 0) begin : g_bad_bits
        initial $error("broadcast and multicast control bits must differ");
    end
endmodule

// File: rtl/rxf_top.sv
// Receive address filter top: configuration bank, destination
// classifier and registered verdict stage. Assumes one frame
// descriptor per in_valid cycle and synchronous active-low reset.
module rxf_top
    import rxf_pkg::*;
#(
    parameter int               ADDR_W     = 48,
    parameter int               LEN_W      = 16,
    parameter int               BC_BIT     = 9,
    parameter int               MC_BIT     = 8,
    parameter logic [REG_W-1:0] DCARE_RST  = 32'h0003_FFFF,
    parameter logic [REG_W-1:0] MAXLEN_RST = 32'h0000_0600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] dest_addr,
    input  logic [LEN_W-1:0]  frame_len,
    output logic              out_valid,
    output logic              accept
);
    localparam int LOW_STA_W = ADDR_W - REG_W;

    cfg_t              cfg;
    logic [REG_W-1:0]  cfg_drop_w;
    logic [REG_W-1:0]  cfg_dcare_w;
    logic [REG_W-1:0]  cfg_maxlen;
    logic [ADDR_W-1:0] station;
    logic              is_bcast;
    logic              is_mcast;
    logic              ucast_hit;
    logic              unused_cfg_bits;

    rxf_cfg_regs #(
        .DCARE_RST (DCARE_RST),
        .MAXLEN_RST(MAXLEN_RST)
    ) u_cfg (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(cfg_we),
        .sel  (cfg_sel),
        .wdata(cfg_wdata),
        .cfg  (cfg)
    );

    // Flatten the record and assemble the station address.
    assign cfg_drop_w  = cfg.drop_w;
    assign cfg_dcare_w = cfg.dcare_w;
    assign cfg_maxlen  = cfg.maxlen;
    assign station     = {cfg.sta_a, cfg.sta_b[REG_W-1 -: LOW_STA_W]};
    assign unused_cfg_bits = ^cfg.sta_b[REG_W-LOW_STA_W-1:0];

    rxf_classify #(
        .ADDR_W(ADDR_W)
    ) u_cls (
        .dest     (dest_addr),
        .station  (station),
        .is_bcast (is_bcast),
        .is_mcast (is_mcast),
        .ucast_hit(ucast_hit)
    );

    rxf_decide #(
        .LEN_W (LEN_W),
        .BC_BIT(BC_BIT),
        .MC_BIT(MC_BIT)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .frame_len (frame_len),
        .len_limit (cfg_maxlen[LEN_W-1:0]),
        .drop_bits ({cfg_drop_w[BC_BIT], cfg_drop_w[MC_BIT]}),
        .dcare_bits({cfg_dcare_w[BC_BIT], cfg_dcare_w[MC_BIT]}),
        .is_bcast  (is_bcast),
        .is_mcast  (is_mcast),
        .ucast_hit (ucast_hit),
        .out_valid (out_valid),
        .accept    (accept)
    );
endmodule

// File: rtl/rxf_chk.sv
// Checker for rxf_top: relates the ports and the configuration state
// across the one-cycle verdict latency. Bound into every rxf_top.
module rxf_chk #(
    parameter int          ADDR_W     = 48,
    parameter int          LEN_W      = 16,
    parameter int          REG_W      = 32,
    parameter int          BC_BIT     = 9,
    parameter int          MC_BIT     = 8,
    parameter logic [31:0] DCARE_RST  = 32'h0003_FFFF,
    parameter logic [31:0] MAXLEN_RST = 32'h0000_0600
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] dest_addr,
    input logic [LEN_W-1:0]  frame_len,
    input logic              out_valid,
    input logic              accept,
    input logic [REG_W-1:0]  drop_w,
    input logic [REG_W-1:0]  dcare_w,
    input logic [REG_W-1:0]  maxlen,
    input logic [ADDR_W-1:0] station
);
    // R1
    strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    no_stray_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R1
    accept_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !accept);
    // R2
    oversize_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && frame_len > maxlen[LEN_W-1:0]) |=> !accept);
    // R4
    bcast_dcare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&dest_addr) && dcare_w[BC_BIT]
         && frame_len <= maxlen[LEN_W-1:0]) |=> accept);
    // R5
    mcast_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dest_addr[ADDR_W-8] && !(&dest_addr)
         && !dcare_w[MC_BIT] && drop_w[MC_BIT]) |=> !accept);
    // R6
    ucast_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dest_addr[ADDR_W-8] && dest_addr != station) |=> !accept);
    // R7
    reset_values_chk: assert property (@(posedge clk)
        !rst_n |=> (maxlen == MAXLEN_RST && dcare_w == DCARE_RST
                    && drop_w == '0 && station == '0));
endmodule

bind rxf_top rxf_chk #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .REG_W     (rxf_pkg::REG_W),
    .BC_BIT    (BC_BIT),
    .MC_BIT    (MC_BIT),
    .DCARE_RST (DCARE_RST),
    .MAXLEN_RST(MAXLEN_RST)
) u_rxf_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .dest_addr(dest_addr),
    .frame_len(frame_len),
    .out_valid(out_valid),
    .accept   (accept),
    .drop_w   (cfg_drop_w),
    .dcare_w  (cfg_dcare_w),
    .maxlen   (cfg_maxlen),
    .station  (station)
);

// File: tb/tb_rxf_top.sv
// Bench for rxf_top: sweeps the policy bits against every address
// class and probes the length boundary; expectations are computed here.
module tb_rxf_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [47:0] dest_addr = '0;
    logic [15:0] frame_len = '0;
    logic        out_valid;
    logic        accept;

    int checks = 0;
    int fails  = 0;

    // Bench-side copy of the configuration, updated on each write.
    logic [31:0] m_drop  = 32'h0;
    logic [31:0] m_dcare = 32'h0003_FFFF;
    logic [31:0] m_sta_a = 32'h0;
    logic [31:0] m_sta_b = 32'h0;
    logic [31:0] m_max   = 32'h0000_0600;

    rxf_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .dest_addr(dest_addr),
        .frame_len(frame_len), .out_valid(out_valid), .accept(accept)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected verdict from R2..R6.
    function automatic bit model(input logic [47:0] d, input logic [15:0] l);
        bit bc = (d == 48'hFFFF_FFFF_FFFF);
        bit mc = d[40];
        if (l > m_max[15:0]) return 1'b0;
        if (bc) return m_dcare[9] ? 1'b1 : !m_drop[9];
        if (mc) return m_dcare[8] ? 1'b1 : !m_drop[8];
        return d == {m_sta_a, m_sta_b[31:16]};
    endfunction

    task automatic check(input string req, input logic [1:0] act,
                         input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {out_valid,accept} actual=%b expected=%b",
                     req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            3'd0: m_drop  = data;
            3'd1: m_dcare = data;
            3'd2: m_sta_a = data;
            3'd3: m_sta_b = data;
            3'd4: m_max   = data;
            default: ;
        endcase
    endtask

    // Present one frame, check the verdict strobe, then its end (R1).
    task automatic send(input string req, input logic [47:0] d,
                        input logic [15:0] l);
        bit exp = model(d, l);
        @(negedge clk);
        in_valid = 1'b1; dest_addr = d; frame_len = l;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {out_valid, accept}, {1'b1, exp});
        @(negedge clk);
        check("R1 strobe ends", {out_valid, accept}, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {out_valid, accept}, 2'b00);
        rst_n = 1'b1;

        // R7: reset policy before any write.
        send("R7 bcast at reset",  48'hFFFF_FFFF_FFFF, 16'h0600);
        send("R7 limit 0x600",     48'hFFFF_FFFF_FFFF, 16'h0601);
        send("R7 mcast at reset",  48'h0100_0000_0000, 16'd64);
        send("R7 station zero",    48'h0000_0000_0000, 16'd64);
        send("R7 station miss",    48'h0000_0000_0001, 16'd64);

        // R8: code 5 writes nothing; limit stays 0x600.
        cfg_write(3'd5, 32'h0000_0010);
        send("R8 bad select",      48'hFFFF_FFFF_FFFF, 16'h0200);

        // R6/R8: station 02:11:22:33:44:55, low half of word 3 junk.
        cfg_write(3'd2, 32'h0211_2233);
        cfg_write(3'd3, 32'h4455_ABCD);

        // R3, R4, R5, R6: sweep all policy bit settings.
        for (int dr = 0; dr < 4; dr++) begin
            for (int dc = 0; dc < 4; dc++) begin
                cfg_write(3'd0, {22'h0, 2'(dr), 8'h00});
                cfg_write(3'd1, {22'h3AB, 2'(dc), 8'hFF});
                send("R3/R4 bcast",        48'hFFFF_FFFF_FFFF, 16'd100);
                send("R5 mcast",           48'h0100_5E00_0001, 16'd100);
                send("R3/R5 mcast FF lead",48'hFFFF_FFFF_FFFE, 16'd100);
                send("R6 ucast hit",       48'h0211_2233_4455, 16'd100);
                for (int b = 0; b < 6; b++) begin
                    send("R6 ucast miss",
                         48'h0211_2233_4455 ^ (48'h02 << (8*b)), 16'd100);
                end
            end
        end

        // R2, R9: limit 0x40 with junk in the upper half.
        cfg_write(3'd1, 32'h0000_0300);
        cfg_write(3'd4, 32'hFFFF_0040);
        for (int l = 16'h3E; l <= 16'h42; l++) begin
            send("R2/R9 bcast length", 48'hFFFF_FFFF_FFFF, 16'(l));
            send("R2/R9 ucast length", 48'h0211_2233_4455, 16'(l));
        end
        send("R2 max length", 48'h0211_2233_4455, 16'hFFFF);

        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks, fails);
        $finish;
    end
endmodule